// File: doc/BRIEF.md
# Bloom Signature Conflict Detector

This block keeps two address signatures for a single software transaction. One holds the addresses the transaction has read and the other the addresses it has written. Each signature is a Bloom filter, a bit vector in which every address sets a few bit positions chosen by hash functions. Instrumentation code in software supplies addresses explicitly through an insert port, with a select that names the target signature. Normal cache activity never adds to the signatures. Evictions never remove anything from them.

A snoop port carries coherence requests seen on the interconnect. Each request holds a physical address and a flag that marks it as a request for exclusive ownership or a shared read. An exclusive request means another agent intends to update the line. It is tested against both signatures. A shared request is tested only against the write signature. When a test may be a hit, the block raises a one-cycle conflict pulse in the following cycle, together with a two-bit field that tells which signatures matched. Aliasing inside a filter can report a conflict for an address that was never inserted, and that is allowed. A conflict for an inserted address is never missed. A clear input empties both signatures so that the next transaction starts from nothing.

Top module: `sig_conflict_detector`

## Requirements
- R1: After reset both signatures are empty, `conflict_o` is 0 and `conflict_src_o` is 2'b00.
- R2: The 6 offset bits of an address are ignored. Within the block address (address bits above bit 5), index 0 is block-address bits [8:0]. Index 1 is the XOR of the 9-bit chunks of block-address bits from bit 9 upward, and the top chunk is zero-padded. An address is a member of a signature when both of its index bits are set there.
- R3: An insert with `ins_vld_i`=1 sets the two index bits of `ins_addr_i` in the write signature when `ins_is_wr_i`=1 and in the read signature when `ins_is_wr_i`=0. The other signature is left unchanged.
- R4: A snoop with `snp_excl_i`=1 is tested against both signatures. `conflict_src_o` bit 1 reports a write-signature hit and bit 0 reports a read-signature hit.
- R5: A snoop with `snp_excl_i`=0 is tested only against the write signature, so `conflict_src_o` bit 0 stays 0 for it.
- R6: A snooped address that was never inserted but whose two indices are both set in a tested signature is reported as a conflict.
- R7: `conflict_o` is 1 for exactly the cycle after a valid snoop that hit, and `conflict_src_o` is valid in that cycle. In any cycle that does not follow a hitting snoop, both are 0.
- R8: When an insert and a snoop arrive in the same cycle, the snoop is tested against the signatures as they were before that insert.
- R9: `clear_i` empties both signatures at the next edge. A snoop in the clear cycle sees the old contents. An insert in the clear cycle is discarded.
- R10: Every address inserted since the last clear gives a hit on any later snoop whose rules test its signature. False negatives never occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Empty both signatures |
| ins_vld_i | input | 1 | Insert request valid |
| ins_is_wr_i | input | 1 | 1: insert into write signature, 0: into read signature |
| ins_addr_i | input | ADDR_W | Physical address to insert |
| snp_vld_i | input | 1 | Snooped coherence request valid |
| snp_excl_i | input | 1 | 1: exclusive request, 0: shared request |
| snp_addr_i | input | ADDR_W | Physical address of the snooped request |
| conflict_o | output | 1 | One-cycle pulse for a possible conflict |
| conflict_src_o | output | 2 | Bit 1: write signature hit, bit 0: read signature hit |

## Verification
Directed snoops pair each inserted address with both request kinds. This separates the exclusive rule from the shared rule and shows which signature is reported. Addresses that change only the line offset, that alias both indices through a matched change in two fold chunks, or that change a single high bit show whether the hashes use the intended bits. Same-cycle insert/snoop and clear/snoop/insert patterns show the ordering within a cycle. A long pseudo-random run over a small address pool, checked against a bench model of both filters, exercises the no-false-negative rule and the mixed hit fields.

// File: rtl/sigcd_pkg.sv
package sigcd_pkg;

   localparam int unsigned SIGCD_ADDR_W   = 40;
   localparam int unsigned SIGCD_OFS_W    = 6;
   localparam int unsigned SIGCD_SIG_BITS = 512;
   localparam int unsigned SIGCD_NUM_HASH = 2;

   typedef enum logic [0:0] {
      HASH_LOW  = 1'b0,
      HASH_FOLD = 1'b1
   } hash_kind_e;

   typedef struct packed {
      logic wr;
      logic rd;
   } sig_hit_t;

endpackage

// File: rtl/sig_hash.sv
module sig_hash
   import sigcd_pkg::*;
#(
   parameter int unsigned ADDR_W = SIGCD_ADDR_W,
   parameter int unsigned OFS_W  = SIGCD_OFS_W,
   parameter int unsigned IDX_W  = 9,
   parameter hash_kind_e  KIND   = HASH_LOW
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [IDX_W-1:0]  idx_o
);

   localparam int unsigned BLK_W  = ADDR_W - OFS_W;
   localparam int unsigned HI_W   = BLK_W - IDX_W;
   localparam int unsigned N_CHNK = (HI_W + IDX_W - 1) / IDX_W;

   logic [BLK_W-1:0] blk;
   assign blk = addr_i[ADDR_W-1:OFS_W];

   if (BLK_W <= IDX_W) begin : g_bad_width
      $error("sig_hash: block address must be wider than the index");
   end

   if (KIND == HASH_LOW) begin : g_low
      assign idx_o = blk[IDX_W-1:0];
   end else begin : g_fold
      logic [HI_W-1:0] hi;
      assign hi = blk[BLK_W-1:IDX_W];

      always_comb begin
         idx_o = '0;
         for (int c = 0; c < int'(N_CHNK); c++) begin
            for (int b = 0; b < int'(IDX_W); b++) begin
               if (c * int'(IDX_W) + b < int'(HI_W)) begin
                  idx_o[b] = idx_o[b] ^ hi[c*IDX_W + b];
               end
            end
         end
      end
   end

endmodule

// File: rtl/sig_filter.sv
module sig_filter
   import sigcd_pkg::*;
#(
   parameter int unsigned SIG_BITS = SIGCD_SIG_BITS,
   parameter int unsigned NUM_HASH = SIGCD_NUM_HASH,
   localparam int unsigned IDX_W   = $clog2(SIG_BITS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clear_i,
   input  logic                          set_en_i,
   input  logic [NUM_HASH-1:0][IDX_W-1:0] set_idx_i,
   input  logic [NUM_HASH-1:0][IDX_W-1:0] test_idx_i,
   output logic                          member_o
);

   logic [SIG_BITS-1:0] bits_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits_q <= '0;
      end else if (clear_i) begin
         bits_q <= '0;
      end else if (set_en_i) begin
         for (int k = 0; k < int'(NUM_HASH); k++) begin
            bits_q[set_idx_i[k]] <= 1'b1;
         end
      end
   end

   always_comb begin
      member_o = 1'b1;
      for (int k = 0; k < int'(NUM_HASH); k++) begin
         member_o = member_o & bits_q[test_idx_i[k]];
      end
   end

endmodule

// File: rtl/sig_snoop_judge.sv
module sig_snoop_judge
   import sigcd_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     snp_vld_i,
   input  logic     snp_excl_i,
   input  logic     rd_member_i,
   input  logic     wr_member_i,
   output logic     conflict_o,
   output sig_hit_t hit_o
);

   sig_hit_t hit_d;

   always_comb begin
      hit_d    = '0;
      hit_d.wr = snp_vld_i & wr_member_i;
      hit_d.rd = snp_vld_i & snp_excl_i & rd_member_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_o      <= '0;
         conflict_o <= 1'b0;
      end else begin
         hit_o      <= hit_d;
         conflict_o <= hit_d.wr | hit_d.rd;
      end
   end

endmodule

// File: rtl/sig_conflict_detector.sv
module sig_conflict_detector
   import sigcd_pkg::*;
#(
   parameter int unsigned ADDR_W   = SIGCD_ADDR_W,
   parameter int unsigned OFS_W    = SIGCD_OFS_W,
   parameter int unsigned SIG_BITS = SIGCD_SIG_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              ins_vld_i,
   input  logic              ins_is_wr_i,
   input  logic [ADDR_W-1:0] ins_addr_i,
   input  logic              snp_vld_i,
   input  logic              snp_excl_i,
   input  logic [ADDR_W-1:0] snp_addr_i,
   output logic              conflict_o,
   output logic [1:0]        conflict_src_o
);

   localparam int unsigned IDX_W    = $clog2(SIG_BITS);
   localparam int unsigned NUM_HASH = SIGCD_NUM_HASH;

   if ((1 << IDX_W) != SIG_BITS) begin : g_chk_pow2
      $error("sig_conflict_detector: SIG_BITS must be a power of two");
   end
   if (ADDR_W <= OFS_W + IDX_W) begin : g_chk_addr
      $error("sig_conflict_detector: ADDR_W too small for offset and index");
   end

   logic [NUM_HASH-1:0][IDX_W-1:0] ins_idx;
   logic [NUM_HASH-1:0][IDX_W-1:0] snp_idx;

   for (genvar k = 0; k < NUM_HASH; k++) begin : g_hash
      localparam hash_kind_e KIND = (k == 0) ? HASH_LOW : HASH_FOLD;

      sig_hash #(
         .ADDR_W (ADDR_W),
         .OFS_W  (OFS_W),
         .IDX_W  (IDX_W),
         .KIND   (KIND)
      ) i_ins_hash (
         .addr_i (ins_addr_i),
         .idx_o  (ins_idx[k])
      );

      sig_hash #(
         .ADDR_W (ADDR_W),
         .OFS_W  (OFS_W),
         .IDX_W  (IDX_W),
         .KIND   (KIND)
      ) i_snp_hash (
         .addr_i (snp_addr_i),
         .idx_o  (snp_idx[k])
      );
   end

   logic rd_set, wr_set;
   logic rd_member, wr_member;

   assign rd_set = ins_vld_i & ~ins_is_wr_i;
   assign wr_set = ins_vld_i &  ins_is_wr_i;

   sig_filter #(
      .SIG_BITS (SIG_BITS),
      .NUM_HASH (NUM_HASH)
   ) i_rd_sig (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (clear_i),
      .set_en_i   (rd_set),
      .set_idx_i  (ins_idx),
      .test_idx_i (snp_idx),
      .member_o   (rd_member)
   );

   sig_filter #(
      .SIG_BITS (SIG_BITS),
      .NUM_HASH (NUM_HASH)
   ) i_wr_sig (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (clear_i),
      .set_en_i   (wr_set),
      .set_idx_i  (ins_idx),
      .test_idx_i (snp_idx),
      .member_o   (wr_member)
   );

   sig_hit_t hit;

   sig_snoop_judge i_judge (
      .clk         (clk),
      .rst_n       (rst_n),
      .snp_vld_i   (snp_vld_i),
      .snp_excl_i  (snp_excl_i),
      .rd_member_i (rd_member),
      .wr_member_i (wr_member),
      .conflict_o  (conflict_o),
      .hit_o       (hit)
   );

   assign conflict_src_o = {hit.wr, hit.rd};

endmodule

// File: rtl/sig_conflict_checker.sv
module sig_conflict_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       clear_i,
   input logic       snp_vld_i,
   input logic       snp_excl_i,
   input logic       conflict_o,
   input logic [1:0] conflict_src_o
);

   // R7: a pulse only follows a valid snoop
   a_r7_pulse_after_snoop: assert property (@(posedge clk) disable iff (!rst_n)
      conflict_o |-> $past(snp_vld_i));

   // R7: the source field is quiet when no conflict is reported
   a_r7_src_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !conflict_o |-> (conflict_src_o == 2'b00));

   // R5: a shared snoop never reports the read signature
   a_r5_shared_no_rd: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(snp_vld_i) && !$past(snp_excl_i)) |-> !conflict_src_o[0]);

   // R9: a snoop the cycle after a clear finds nothing
   a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(clear_i, 2) && $past(snp_vld_i)) |-> !conflict_o);

   // R4: any reported source implies a conflict
   a_r4_src_implies_conflict: assert property (@(posedge clk) disable iff (!rst_n)
      (conflict_src_o != 2'b00) |-> conflict_o);

endmodule

bind sig_conflict_detector sig_conflict_checker i_sig_conflict_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .clear_i        (clear_i),
   .snp_vld_i      (snp_vld_i),
   .snp_excl_i     (snp_excl_i),
   .conflict_o     (conflict_o),
   .conflict_src_o (conflict_src_o)
);

// File: tb/test_sig_conflict_detector.sv
`timescale 1ns/1ps
module test_sig_conflict_detector;

   localparam int AW  = 40;
   localparam int OFS = 6;
   localparam int IW  = 9;
   localparam int NB  = 512;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clear_i = 1'b0;
   logic          ins_vld_i = 1'b0;
   logic          ins_is_wr_i = 1'b0;
   logic [AW-1:0] ins_addr_i = '0;
   logic          snp_vld_i = 1'b0;
   logic          snp_excl_i = 1'b0;
   logic [AW-1:0] snp_addr_i = '0;
   logic          conflict_o;
   logic [1:0]    conflict_src_o;

   always #4 clk = ~clk;

   sig_conflict_detector i_sig_conflict_detector (
      .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
      .ins_vld_i(ins_vld_i), .ins_is_wr_i(ins_is_wr_i), .ins_addr_i(ins_addr_i),
      .snp_vld_i(snp_vld_i), .snp_excl_i(snp_excl_i), .snp_addr_i(snp_addr_i),
      .conflict_o(conflict_o), .conflict_src_o(conflict_src_o));

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;

   // bench model of the two filters
   logic [NB-1:0] m_rd = '0;
   logic [NB-1:0] m_wr = '0;

   logic [2:0] q_exp[$];
   string      q_tag[$];

   function automatic logic [IW-1:0] h0(input logic [AW-1:0] a);
      logic [AW-OFS-1:0] b = a[AW-1:OFS];
      return b[IW-1:0];
   endfunction

   function automatic logic [IW-1:0] h1(input logic [AW-1:0] a);
      logic [AW-OFS-1:0] b = a[AW-1:OFS];
      logic [IW-1:0] r = '0;
      for (int i = IW; i < AW - OFS; i++) r[(i - IW) % IW] ^= b[i];
      return r;
   endfunction

   task automatic step(input logic clr, input logic iv, input logic iw,
                       input logic [AW-1:0] ia, input logic sv, input logic sx,
                       input logic [AW-1:0] sa, input string tag);
      logic rh, wh;
      @(negedge clk);
      clear_i = clr; ins_vld_i = iv; ins_is_wr_i = iw; ins_addr_i = ia;
      snp_vld_i = sv; snp_excl_i = sx; snp_addr_i = sa;
      wh = sv && m_wr[h0(sa)] && m_wr[h1(sa)];
      rh = sv && sx && m_rd[h0(sa)] && m_rd[h1(sa)];
      q_exp.push_back({wh | rh, wh, rh});
      q_tag.push_back(tag);
      if (clr) begin
         m_rd = '0; m_wr = '0;
      end else if (iv) begin
         if (iw) begin m_wr[h0(ia)] = 1'b1; m_wr[h1(ia)] = 1'b1; end
         else    begin m_rd[h0(ia)] = 1'b1; m_rd[h1(ia)] = 1'b1; end
      end
   endtask

   task automatic ins(input logic iw, input logic [AW-1:0] a, input string tag);
      step(1'b0, 1'b1, iw, a, 1'b0, 1'b0, '0, tag);
   endtask

   task automatic snp(input logic x, input logic [AW-1:0] a, input string tag);
      step(1'b0, 1'b0, 1'b0, '0, 1'b1, x, a, tag);
   endtask

   task automatic idle(input string tag);
      step(1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0, tag);
   endtask

   // monitor: compares one expected item per cycle
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q_exp.size() > 0) begin
            logic [2:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            n_run++;
            if ({conflict_o, conflict_src_o} !== e) begin
               n_fail++;
               $display("FAIL %s: got conflict=%b src=%b, expected conflict=%b src=%b",
                        t, conflict_o, conflict_src_o, e[2], e[1:0]);
            end
         end
      end
   end

   initial begin
      #(8 * 100000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] a_addr, b_addr, c_addr, alias_a, hib_a;
      logic [AW-1:0] pool[8];
      logic [15:0] lfsr;
      a_addr  = 40'h12_3456_7840;
      b_addr  = 40'h0A_BCDE_F000;
      c_addr  = 40'h33_0000_1240;
      alias_a = a_addr ^ (40'h1 << (OFS + 9)) ^ (40'h1 << (OFS + 18));
      hib_a   = a_addr ^ (40'h1 << 35);

      repeat (3) @(negedge clk);
      n_run++;
      if (conflict_o !== 1'b0 || conflict_src_o !== 2'b00) begin
         n_fail++;
         $display("FAIL R1 in reset: got %b/%b, expected 0/00", conflict_o, conflict_src_o);
      end
      rst_n = 1'b1;

      snp(1'b1, a_addr, "R1 empty after reset");
      snp(1'b0, a_addr, "R1 empty after reset shared");

      ins(1'b0, a_addr, "R3 read insert");
      snp(1'b0, a_addr, "R5 shared ignores read sig");
      snp(1'b1, a_addr, "R4 exclusive hits read sig");
      snp(1'b1, a_addr | 40'h3F, "R2 offset bits ignored");
      idle("R7 no pulse without snoop");
      snp(1'b1, alias_a, "R6 alias false positive");
      snp(1'b1, hib_a, "R2 high bit changes index1");

      ins(1'b1, b_addr, "R3 write insert");
      snp(1'b0, b_addr, "R5 shared hits write sig");
      snp(1'b1, b_addr, "R4 exclusive hits write sig");
      snp(1'b1, b_addr, "R7 back-to-back pulse");
      idle("R7 pulse ends");

      step(1'b0, 1'b1, 1'b1, c_addr, 1'b1, 1'b1, c_addr, "R8 snoop sees pre-insert");
      snp(1'b1, c_addr, "R8 later snoop sees insert");
      ins(1'b1, a_addr, "R10 write insert of read addr");
      snp(1'b1, a_addr, "R4 both signatures hit");

      step(1'b1, 1'b0, 1'b0, '0, 1'b1, 1'b1, a_addr, "R9 snoop in clear cycle sees old");
      snp(1'b1, a_addr, "R9 cleared");
      snp(1'b0, b_addr, "R9 cleared write sig");
      step(1'b1, 1'b1, 1'b1, c_addr, 1'b0, 1'b0, '0, "R9 clear with insert");
      snp(1'b1, c_addr, "R9 insert in clear cycle dropped");

      for (int i = 0; i < 8; i++) pool[i] = {8'(i * 37 + 5), 32'(i * 32'h0913_7A40)};
      lfsr = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
         logic [2:0] sel;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         sel = lfsr[2:0];
         if (lfsr[9:4] == 0)
            step(1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0, "R10 random clear");
         else
            step(1'b0, lfsr[5], lfsr[6], pool[lfsr[12:10]], lfsr[7], lfsr[8],
                 pool[sel], "R10 random mix");
      end
      idle("R7 drain");
      idle("R7 drain");
      @(negedge clk);
      @(negedge clk);
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule